// File: doc/BRIEF.md
# Message-Signalled Interrupt Target

This block receives message-signalled interrupts and turns them into 64 separate interrupt lines. A single write on a message port carries a vector number in its data word. When that number is a valid index, the corresponding pending bit is set. One shared pending set is viewed by two independent destinations: a host interrupt controller and a secondary processor. Each destination has its own mask word and its own status word.

A 32-bit register interface reaches the block's state. Software can read the pending set, raise vectors and clear vectors. It can also choose the host trigger mode per vector and program both masks. Each of these words comes as a pair: the low word covers vectors 0 to 31 and the high word covers vectors 32 to 63. A host vector in edge mode gives a one-cycle pulse for each raise event. A host vector in level mode holds its line high for as long as the vector is pending and unmasked. The secondary destination is always level.

Top module: `msix_target`

## Requirements
- R1: After reset the pending set is zero, every bit of both mask words is 1, every host mode bit is 0 (level), and `host_irq` and `aux_irq` are all zero.
- R2: A message (`msg_valid` high) whose data value v is below 64 sets pending bit v one clock later. The pending set reads at offset 0x00 (vectors 0–31, bit i = vector i) and at 0x04 (vectors 32–63, bit i = vector 32+i).
- R3: A message whose data value is 64 or greater changes no pending bit.
- R4: Writing to offset 0x10 (vectors 0–31) or 0x14 (vectors 32–63) clears each pending bit written as 1 and leaves bits written as 0 unchanged. Both clear offsets read as zero.
- R5: When a raise and a clear of the same vector fall in the same cycle, the vector is pending afterwards.
- R6: Writing to offset 0x00 or 0x04 sets each pending bit written as 1 (software raise), with the same bit mapping as R2.
- R7: Host status reads at 0x80 (low) and 0x90 (high) as pending AND NOT host mask. Secondary status reads at 0xA0 and 0xB0 as pending AND NOT secondary mask.
- R8: Host mode words sit at 0x20 and 0x30, host mask words at 0x40 and 0x50, and secondary mask words at 0x60 and 0x70. Each reads back the value last written. They change only on a write to their own offset.
- R9: For a host vector with mode bit 0, `host_irq[v]` is 1 exactly while vector v is pending and its host mask bit is 0.
- R10: For a host vector with mode bit 1, `host_irq[v]` is high for one cycle in the clock after each raise of v, provided the host mask bit was 0 when the raise happened. Otherwise it stays low, even while v is still pending.
- R11: `aux_irq[v]` is 1 exactly while vector v is pending and its secondary mask bit is 0.
- R12: Reads from any other offset return zero, and writes to any other offset change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Inbound message write strobe |
| msg_data | input | MSG_W | Message data word carrying the vector number |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| host_irq | output | 64 | Per-vector host interrupt lines |
| aux_irq | output | 64 | Per-vector secondary-processor interrupt lines |

## Verification
The bench builds the block with its default widths: a 32-bit message data word and an 8-bit register offset. The full data width lets messages carry values such as 64 and 1000, so the out-of-range case can be exercised. With 8 address bits, every offset of both halves can be hit, and so can unmapped offsets such as 0x08. Vectors are chosen on both sides of the half boundary (5, 7, 33 and 40), so the low and high words of every register pair are exercised.

// File: rtl/msix_pkg.sv
package msix_pkg;
    localparam int NVEC      = 64;
    localparam int WORD      = 32;
    localparam int NHALF     = NVEC / WORD;
    // byte offsets of the low halves; pair step differs by word kind
    localparam int OFF_RAISE = 'h00;
    localparam int OFF_CLEAR = 'h10;
    localparam int OFF_CFG   = 'h20;
    localparam int OFF_HMASK = 'h40;
    localparam int OFF_AMASK = 'h60;
    localparam int OFF_HSTAT = 'h80;
    localparam int OFF_ASTAT = 'hA0;
    localparam int STEP_PEND = 'h04;
    localparam int STEP_HALF = 'h10;

    typedef struct packed {
        logic [NVEC-1:0] cfg;
        logic [NVEC-1:0] hmask;
        logic [NVEC-1:0] amask;
    } ctl_t;

    typedef struct packed {
        logic [NVEC-1:0] pend;
        logic [NVEC-1:0] pulse;
    } core_t;
endpackage

// File: rtl/msix_msg_decode.sv
module msix_msg_decode
    import msix_pkg::*;
#(
    parameter int MSG_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                msg_valid,
    input  logic [MSG_W-1:0]    msg_data,
    output logic [NVEC-1:0]     raise_msg
);
    always_comb begin
        for (int i = 0; i < NVEC; i++) begin
            raise_msg[i] = msg_valid && (msg_data == MSG_W'(i));
        end
    end

    assert_single_vec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(raise_msg));

    assert_range_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_data >= MSG_W'(NVEC)) |-> (raise_msg == '0));
endmodule

// File: rtl/msix_regs.sv
module msix_regs
    import msix_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wen,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [WORD-1:0]     reg_wdata,
    input  logic [NVEC-1:0]     pend,
    input  logic [NVEC-1:0]     hstat,
    input  logic [NVEC-1:0]     astat,
    output ctl_t                ctl,
    output logic [NVEC-1:0]     sw_raise,
    output logic [NVEC-1:0]     sw_clear,
    output logic [WORD-1:0]     reg_rdata
);
    ctl_t ctl_d, ctl_q;
    logic hit_d;

    always_comb begin
        ctl_d     = ctl_q;
        sw_raise  = '0;
        sw_clear  = '0;
        reg_rdata = '0;
        hit_d     = 1'b0;
        for (int h = 0; h < NHALF; h++) begin
            if (reg_wen) begin
                if (reg_addr == ADDR_W'(OFF_RAISE + h*STEP_PEND))
                    sw_raise[h*WORD +: WORD] = reg_wdata;
                if (reg_addr == ADDR_W'(OFF_CLEAR + h*STEP_PEND))
                    sw_clear[h*WORD +: WORD] = reg_wdata;
                if (reg_addr == ADDR_W'(OFF_CFG + h*STEP_HALF)) begin
                    ctl_d.cfg[h*WORD +: WORD] = reg_wdata;
                    hit_d = 1'b1;
                end
                if (reg_addr == ADDR_W'(OFF_HMASK + h*STEP_HALF)) begin
                    ctl_d.hmask[h*WORD +: WORD] = reg_wdata;
                    hit_d = 1'b1;
                end
                if (reg_addr == ADDR_W'(OFF_AMASK + h*STEP_HALF)) begin
                    ctl_d.amask[h*WORD +: WORD] = reg_wdata;
                    hit_d = 1'b1;
                end
            end
            if (reg_addr == ADDR_W'(OFF_RAISE + h*STEP_PEND)) reg_rdata = pend[h*WORD +: WORD];
            if (reg_addr == ADDR_W'(OFF_CFG   + h*STEP_HALF)) reg_rdata = ctl_q.cfg[h*WORD +: WORD];
            if (reg_addr == ADDR_W'(OFF_HMASK + h*STEP_HALF)) reg_rdata = ctl_q.hmask[h*WORD +: WORD];
            if (reg_addr == ADDR_W'(OFF_AMASK + h*STEP_HALF)) reg_rdata = ctl_q.amask[h*WORD +: WORD];
            if (reg_addr == ADDR_W'(OFF_HSTAT + h*STEP_HALF)) reg_rdata = hstat[h*WORD +: WORD];
            if (reg_addr == ADDR_W'(OFF_ASTAT + h*STEP_HALF)) reg_rdata = astat[h*WORD +: WORD];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.cfg   <= '0;
            ctl_q.hmask <= '1;
            ctl_q.amask <= '1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ctl = ctl_q;

    assert_ctl_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wen |=> $stable(ctl_q));

    assert_unmapped_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && !hit_d) |=> $stable(ctl_q));
endmodule

// File: rtl/msix_core.sv
module msix_core
    import msix_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NVEC-1:0]     raise_msg,
    input  logic [NVEC-1:0]     sw_raise,
    input  logic [NVEC-1:0]     sw_clear,
    input  ctl_t                ctl,
    output logic [NVEC-1:0]     pend,
    output logic [NVEC-1:0]     hstat,
    output logic [NVEC-1:0]     astat,
    output logic [NVEC-1:0]     host_irq,
    output logic [NVEC-1:0]     aux_irq
);
    core_t core_d, core_q;
    logic [NVEC-1:0] raise_all;

    always_comb begin
        raise_all     = raise_msg | sw_raise;
        core_d.pend   = (core_q.pend & ~sw_clear) | raise_all;
        core_d.pulse  = raise_all & ctl.cfg & ~ctl.hmask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign pend     = core_q.pend;
    assign hstat    = core_q.pend & ~ctl.hmask;
    assign astat    = core_q.pend & ~ctl.amask;
    assign host_irq = core_q.pulse | (hstat & ~ctl.cfg);
    assign aux_irq  = astat;

    assert_raise_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_all != '0) |=> ((core_q.pend & $past(raise_all)) == $past(raise_all)));

    assert_clear_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((sw_clear & ~raise_all) != '0) |=> ((core_q.pend & $past(sw_clear & ~raise_all)) == '0));

    assert_edge_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((host_irq & ctl.cfg) & ~$past(raise_all)) == '0);

    assert_aux_subset_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_irq & ~core_q.pend) == '0);
endmodule

// File: rtl/msix_target.sv
module msix_target
    import msix_pkg::*;
#(
    parameter int MSG_W  = 32,
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                msg_valid,
    input  logic [MSG_W-1:0]    msg_data,
    input  logic                reg_wen,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic [63:0]         host_irq,
    output logic [63:0]         aux_irq
);
    logic [NVEC-1:0] raise_msg, sw_raise, sw_clear, pend, hstat, astat;
    ctl_t ctl;

    msix_msg_decode #(.MSG_W(MSG_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_data(msg_data),
        .raise_msg(raise_msg)
    );

    msix_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .pend(pend), .hstat(hstat), .astat(astat),
        .ctl(ctl), .sw_raise(sw_raise), .sw_clear(sw_clear), .reg_rdata(reg_rdata)
    );

    msix_core u_core (
        .clk(clk), .rst_n(rst_n), .raise_msg(raise_msg), .sw_raise(sw_raise),
        .sw_clear(sw_clear), .ctl(ctl), .pend(pend), .hstat(hstat), .astat(astat),
        .host_irq(host_irq), .aux_irq(aux_irq)
    );
endmodule

// File: tb/sim_msix_target.sv
`timescale 1ns/1ps
module sim_msix_target;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msg_valid = 1'b0;
    logic [31:0] msg_data = '0;
    logic        reg_wen = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] host_irq, aux_irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit started = 0;

    bit [63:0] m_pend, m_pulse, m_cfg, m_hm, m_am;

    always #10 clk = ~clk;

    msix_target u0 (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_data(msg_data),
        .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .host_irq(host_irq), .aux_irq(aux_irq)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference, evaluated vector by vector
    always @(posedge clk) begin
        bit [63:0] rs, cl, np;
        if (!rst_n) begin
            m_pend = '0; m_pulse = '0; m_cfg = '0; m_hm = '1; m_am = '1;
        end else begin
            rs = '0; cl = '0;
            if (msg_valid && msg_data < 64) rs[msg_data[5:0]] = 1'b1;
            if (reg_wen) begin
                case (reg_addr)
                    8'h00: rs[31:0]  = rs[31:0]  | reg_wdata;
                    8'h04: rs[63:32] = rs[63:32] | reg_wdata;
                    8'h10: cl[31:0]  = reg_wdata;
                    8'h14: cl[63:32] = reg_wdata;
                    default: ;
                endcase
            end
            for (int v = 0; v < 64; v++) begin
                m_pulse[v] = rs[v] && m_cfg[v] && !m_hm[v];
                np[v] = rs[v] ? 1'b1 : (cl[v] ? 1'b0 : m_pend[v]);
            end
            m_pend = np;
            if (reg_wen) begin
                case (reg_addr)
                    8'h20: m_cfg[31:0]  = reg_wdata;
                    8'h30: m_cfg[63:32] = reg_wdata;
                    8'h40: m_hm[31:0]   = reg_wdata;
                    8'h50: m_hm[63:32]  = reg_wdata;
                    8'h60: m_am[31:0]   = reg_wdata;
                    8'h70: m_am[63:32]  = reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison of both output vectors (R9 R10 R11)
    always @(negedge clk) begin
        if (started) begin
            logic [63:0] eh, ea;
            for (int v = 0; v < 64; v++) begin
                eh[v] = m_cfg[v] ? m_pulse[v] : (m_pend[v] && !m_hm[v]);
                ea[v] = m_pend[v] && !m_am[v];
            end
            chk("R9/R10 host_irq vs model", host_irq, eh);
            chk("R11 aux_irq vs model", aux_irq, ea);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired, no requirement completed");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic msg(input logic [31:0] v);
        @(negedge clk); msg_valid = 1'b1; msg_data = v;
        @(negedge clk); msg_valid = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); reg_addr = a; #1;
        chk(tag, {32'h0, reg_rdata}, {32'h0, exp});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        started = 1;
        // R1 reset state
        rd(8'h00, 32'h0, "R1 pending low");
        rd(8'h04, 32'h0, "R1 pending high");
        rd(8'h40, 32'hFFFF_FFFF, "R1 host mask low");
        rd(8'h70, 32'hFFFF_FFFF, "R1 aux mask high");
        rd(8'h30, 32'h0, "R1 mode high");
        chk("R1 host_irq idle", host_irq, 64'h0);
        // R2 messages into both halves
        msg(32'd5);
        msg(32'd40);
        rd(8'h00, 32'h20, "R2 pending low v5");
        rd(8'h04, 32'h100, "R2 pending high v40");
        // R3 out-of-range values
        msg(32'd64);
        msg(32'd1000);
        rd(8'h00, 32'h20, "R3 low unchanged");
        rd(8'h04, 32'h100, "R3 high unchanged");
        // R7 R9 host unmasked, level mode
        wr(8'h40, 32'h0);
        wr(8'h50, 32'h0);
        chk("R9 host level lines", host_irq, 64'h0000_0100_0000_0020);
        rd(8'h80, 32'h20, "R7 host status low");
        rd(8'h90, 32'h100, "R7 host status high");
        rd(8'hA0, 32'h0, "R7 aux status masked");
        // R11 aux unmask vector 5 only
        wr(8'h60, ~32'h20);
        chk("R11 aux line v5", aux_irq, 64'h20);
        rd(8'hA0, 32'h20, "R7 aux status low");
        rd(8'hB0, 32'h0, "R7 aux status high masked");
        // R4 clear
        wr(8'h10, 32'h20);
        rd(8'h00, 32'h0, "R4 cleared v5");
        rd(8'h10, 32'h0, "R4 clear reads zero");
        chk("R4 aux line dropped", aux_irq, 64'h0);
        // R5 same-cycle raise and clear of vector 40
        @(negedge clk);
        msg_valid = 1'b1; msg_data = 32'd40;
        reg_wen = 1'b1; reg_addr = 8'h14; reg_wdata = 32'h100;
        @(negedge clk);
        msg_valid = 1'b0; reg_wen = 1'b0;
        rd(8'h04, 32'h100, "R5 raise wins");
        wr(8'h14, 32'h100);
        rd(8'h04, 32'h0, "R4 cleared v40");
        // R6 software raise of vector 33
        wr(8'h04, 32'h2);
        rd(8'h04, 32'h2, "R6 software raise");
        chk("R9 host line v33", host_irq, 64'h0000_0002_0000_0000);
        // R8 mode word readback
        wr(8'h20, 32'h80);
        rd(8'h20, 32'h80, "R8 mode low");
        rd(8'h30, 32'h0, "R8 mode high");
        // R10 edge pulse
        msg(32'd7);
        chk("R10 pulse cycle", {63'h0, host_irq[7]}, 64'h1);
        @(negedge clk);
        chk("R10 pulse ends", {63'h0, host_irq[7]}, 64'h0);
        rd(8'h00, 32'h80, "R10 still pending");
        msg(32'd7);
        msg(32'd7);
        chk("R10 second pulse", {63'h0, host_irq[7]}, 64'h1);
        // R10 masked at raise time: no pulse
        wr(8'h40, 32'h80);
        rd(8'h40, 32'h80, "R8 host mask low");
        wr(8'h10, 32'h80);
        msg(32'd7);
        chk("R10 masked no pulse", {63'h0, host_irq[7]}, 64'h0);
        // R12 unmapped offsets
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'hC0, 32'hFFFF_FFFF);
        rd(8'h08, 32'h0, "R12 unmapped read");
        rd(8'hC0, 32'h0, "R12 unmapped read high");
        rd(8'h00, 32'h80, "R12 pending untouched");
        rd(8'h04, 32'h2, "R12 pending high untouched");
        rd(8'h60, ~32'h20, "R12 aux mask untouched");
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule